// File: doc/BRIEF.md
# Per-Transfer Parallel Display Strobe Generator

This block turns a stream of data words into the control waveforms of a parallel display bus. A word is offered on a valid/ready interface together with three flag bits. When the word is taken, a new local start point is opened. From that point a half-step counter runs, and every control pin changes state at its own programmed rise and fall offsets. Each offset is counted in half clock periods. Each pin leaves the block as an early/late pair that an output cell serialises: the early bit holds the first half of the cycle and the late bit the second half.

The flags choose the addressed display, the transfer direction and the register-select level. Seven general-purpose pins can each be given a role: write strobe, read strobe, register select, or a strobe that fires on every transfer. Two active-low chip selects address two displays. On a write the word is driven on the bus. On a read the bus is released and the incoming value is captured at a programmed half-step.

The sequencer has two states. In `S_IDLE` it waits for a word. The transition `take` (valid while idle) moves it to `S_XFER`. In `S_XFER` the half-step counter advances by two each cycle. The transition `done` is taken in the cycle whose late half-step reaches the programmed length, and it returns the sequencer to `S_IDLE`.

Top module: `dstb_strobe_gen`

## Requirements
- R1: `in_ready_o` is high in idle and after reset. A word is taken on a clock edge where valid and ready are both high. Ready then stays low for ceil(`cfg_len_i`/2) cycles (at least one), and returns high in the next cycle.
- R2: In the first cycle after a word is taken, the half-step counter is 0. In the k-th cycle of a transfer (counting from 0), the early output bits show half-step 2k and the late bits show half-step 2k+1.
- R3: A pin with a strobe role that is active in the current transfer outputs the inverse of its idle level in every half-step h with up <= h < down. In all other half-steps it outputs its idle level. An odd offset therefore takes effect on the late bit.
- R4: Pin role codes in `pin_role_i` (two bits per pin) are: 0 = write strobe, active only on writes; 1 = read strobe, active only on reads; 2 = register select; 3 = active on every transfer. The flag bits are: `in_flags_i[0]` = display select, `in_flags_i[1]` = 1 for a read and 0 for a write, `in_flags_i[2]` = register-select level.
- R5: A pin with role 2 drives the word's register-select flag for the whole transfer and ignores its offsets.
- R6: Chip select d (active low) goes low only in transfers whose display-select flag equals d, and only for half-steps `cfg_cs_up_i` <= h < `cfg_cs_dn_i`. The other chip select stays high. At most one chip select is low at any time.
- R7: Outside a transfer, every pin shows its `pin_idle_i` level on both halves, and both chip selects are high.
- R8: During a write transfer `bus_oe_o` is 1 and `bus_o` carries the word. During a read transfer and in idle, `bus_oe_o` is 0.
- R9: On a read, `bus_i` is captured at the end of half-step `cfg_cap_i`. An even value takes the mid-cycle (falling edge) sample of cycle `cfg_cap_i`/2. An odd value takes the sample at the rising edge that ends that cycle. `rd_data_o` holds the captured value, and `rd_valid_o` pulses for one cycle, in the cycle after the capture cycle.
- R10: A new word or new flags presented while a transfer runs have no effect on that transfer. The word is taken only once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Word can be taken |
| in_word_i | input | DW | Data word |
| in_flags_i | input | 3 | {register select, read, display select} |
| cfg_len_i | input | TW | Transfer length in half-steps |
| cfg_cap_i | input | TW | Read capture half-step |
| cfg_cs_up_i | input | TW | Chip-select assert half-step |
| cfg_cs_dn_i | input | TW | Chip-select release half-step |
| pin_up_i | input | NPIN*TW | Per-pin rise offsets |
| pin_dn_i | input | NPIN*TW | Per-pin fall offsets |
| pin_role_i | input | 2*NPIN | Per-pin role codes |
| pin_idle_i | input | NPIN | Per-pin idle levels |
| cs_early_o | output | 2 | Chip selects, first half of cycle |
| cs_late_o | output | 2 | Chip selects, second half of cycle |
| pin_early_o | output | NPIN | Strobe pins, first half of cycle |
| pin_late_o | output | NPIN | Strobe pins, second half of cycle |
| bus_o | output | DW | Write data |
| bus_oe_o | output | 1 | Bus drive enable |
| bus_i | input | DW | Read data from the display |
| rd_data_o | output | DW | Captured read value |
| rd_valid_o | output | 1 | Read value strobe |

## Verification
The hardest case to reach is the difference between an even and an odd capture offset. The two can only be told apart if `bus_i` changes inside the capture cycle itself. To reach it, the driver forks a process during each read that puts one value on the bus just after the rising edge of cycle `cfg_cap_i`/2 and a second value just after its falling edge. The expected result then depends only on the parity of the offset. Back-to-back words, whose flags change while the previous transfer is still running, exercise the latching required by R10.

// File: rtl/dstb_pkg.sv
package dstb_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_XFER = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        ROLE_WR  = 2'd0,
        ROLE_RD  = 2'd1,
        ROLE_RS  = 2'd2,
        ROLE_ALL = 2'd3
    } pin_role_e;

    localparam int FLAG_W   = 3;
    localparam int FLAG_SEL = 0;
    localparam int FLAG_RD  = 1;
    localparam int FLAG_RS  = 2;

endpackage

// File: rtl/dstb_seq.sv
module dstb_seq
    import dstb_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DW-1:0]     word_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [TW-1:0]     len_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic [TW-1:0]     k_o,
    output logic [DW-1:0]     word_o,
    output logic              sel_o,
    output logic              rd_o,
    output logic              rs_o
);
    localparam int HW = TW + 2;

    seq_state_e        state_q, state_d;
    logic [TW-1:0]     k_q;
    logic [DW-1:0]     word_q;
    logic [FLAG_W-1:0] flags_q;
    logic [HW-1:0]     next_half;
    logic              take, done;

    // half-step that opens the following cycle: 2k+2
    always_comb begin
        next_half = {1'b0, k_q, 1'b0} + HW'(2);
        take      = (state_q == S_IDLE) && valid_i;
        done      = (state_q == S_XFER) && (next_half >= {2'b00, len_i});
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take) state_d = S_XFER;
            S_XFER: if (done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q     <= '0;
            word_q  <= '0;
            flags_q <= '0;
        end else if (take) begin
            k_q     <= '0;
            word_q  <= word_i;
            flags_q <= flags_i;
        end else if (state_q == S_XFER) begin
            k_q <= k_q + 1'b1;
        end
    end

    always_comb begin
        ready_o = (state_q == S_IDLE);
        busy_o  = (state_q == S_XFER);
        k_o     = k_q;
        word_o  = word_q;
        sel_o   = flags_q[FLAG_SEL];
        rd_o    = flags_q[FLAG_RD];
        rs_o    = flags_q[FLAG_RS];
    end

    // R1: no handshake while a transfer runs
    a_r1_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ready_o);

    // R10: the latched word and flags hold for the whole transfer
    a_r10_latched_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(word_q) && $stable(flags_q)));

    // R2: every transfer starts at half-step zero
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (k_q == '0));

endmodule

// File: rtl/dstb_edge.sv
module dstb_edge #(
    parameter int TW = 8
) (
    input  logic [TW-1:0] k_i,
    input  logic          active_i,
    input  logic          idle_i,
    input  logic          level_mode_i,
    input  logic          level_i,
    input  logic [TW-1:0] up_i,
    input  logic [TW-1:0] dn_i,
    output logic          early_o,
    output logic          late_o
);
    logic [TW:0] h_early, h_late;
    logic        win_early, win_late;

    always_comb begin
        h_early   = {k_i, 1'b0};
        h_late    = {k_i, 1'b1};
        win_early = (h_early >= {1'b0, up_i}) && (h_early < {1'b0, dn_i});
        win_late  = (h_late  >= {1'b0, up_i}) && (h_late  < {1'b0, dn_i});
        if (!active_i) begin
            early_o = idle_i;
            late_o  = idle_i;
        end else if (level_mode_i) begin
            early_o = level_i;
            late_o  = level_i;
        end else begin
            early_o = idle_i ^ win_early;
            late_o  = idle_i ^ win_late;
        end
    end

endmodule

// File: rtl/dstb_rdcap.sv
module dstb_rdcap #(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [TW-1:0] k_i,
    input  logic [TW-1:0] cap_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o
);
    logic [DW-1:0] mid_q;
    logic          hit;

    // mid-cycle sample closes every even half-step
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) mid_q <= '0;
        else        mid_q <= bus_i;
    end

    always_comb hit = arm_i && (k_i == {1'b0, cap_i[TW-1:1]});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= hit;
            if (hit) rd_data_o <= cap_i[0] ? bus_i : mid_q;
        end
    end

    // R9: one capture per read transfer
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

endmodule

// File: rtl/dstb_strobe_gen.sv
module dstb_strobe_gen
    import dstb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TW   = 8,
    parameter int NPIN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DW-1:0]     in_word_i,
    input  logic [2:0]        in_flags_i,
    input  logic [TW-1:0]     cfg_len_i,
    input  logic [TW-1:0]     cfg_cap_i,
    input  logic [TW-1:0]     cfg_cs_up_i,
    input  logic [TW-1:0]     cfg_cs_dn_i,
    input  logic [NPIN*TW-1:0] pin_up_i,
    input  logic [NPIN*TW-1:0] pin_dn_i,
    input  logic [2*NPIN-1:0] pin_role_i,
    input  logic [NPIN-1:0]   pin_idle_i,
    output logic [1:0]        cs_early_o,
    output logic [1:0]        cs_late_o,
    output logic [NPIN-1:0]   pin_early_o,
    output logic [NPIN-1:0]   pin_late_o,
    output logic [DW-1:0]     bus_o,
    output logic              bus_oe_o,
    input  logic [DW-1:0]     bus_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              rd_valid_o
);
    localparam int NDISP = 2;

    logic          busy, sel, rd, rs;
    logic [TW-1:0] k;
    logic [DW-1:0] word;

    dstb_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid_i),
        .word_i  (in_word_i),
        .flags_i (in_flags_i),
        .len_i   (cfg_len_i),
        .ready_o (in_ready_o),
        .busy_o  (busy),
        .k_o     (k),
        .word_o  (word),
        .sel_o   (sel),
        .rd_o    (rd),
        .rs_o    (rs)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pin_role_e role;
        logic      act;
        always_comb begin
            role = pin_role_e'(pin_role_i[2*p +: 2]);
            unique case (role)
                ROLE_WR:  act = busy && !rd;
                ROLE_RD:  act = busy && rd;
                ROLE_RS:  act = busy;
                ROLE_ALL: act = busy;
            endcase
        end
        dstb_edge #(.TW(TW)) u_edge (
            .k_i          (k),
            .active_i     (act),
            .idle_i       (pin_idle_i[p]),
            .level_mode_i (role == ROLE_RS),
            .level_i      (rs),
            .up_i         (pin_up_i[p*TW +: TW]),
            .dn_i         (pin_dn_i[p*TW +: TW]),
            .early_o      (pin_early_o[p]),
            .late_o       (pin_late_o[p])
        );
    end

    for (genvar d = 0; d < NDISP; d++) begin : g_cs
        logic act;
        always_comb act = busy && (sel == 1'(d));
        dstb_edge #(.TW(TW)) u_edge (
            .k_i          (k),
            .active_i     (act),
            .idle_i       (1'b1),
            .level_mode_i (1'b0),
            .level_i      (1'b0),
            .up_i         (cfg_cs_up_i),
            .dn_i         (cfg_cs_dn_i),
            .early_o      (cs_early_o[d]),
            .late_o       (cs_late_o[d])
        );
    end

    always_comb begin
        bus_o    = word;
        bus_oe_o = busy && !rd;
    end

    dstb_rdcap #(.DW(DW), .TW(TW)) u_rdcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (busy && rd),
        .k_i        (k),
        .cap_i      (cfg_cap_i),
        .bus_i      (bus_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    // R6: never two displays selected
    a_r6_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~cs_early_o) <= 1) && ($countones(~cs_late_o) <= 1));

    // R7: resting levels between transfers
    a_r7_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (pin_early_o == pin_idle_i && pin_late_o == pin_idle_i
                        && cs_early_o == 2'b11 && cs_late_o == 2'b11));

    // R8: bus released outside writes
    a_r8_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o || rd) |-> !bus_oe_o);

    // R9: capture strobe only follows a read transfer
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(busy && rd));

endmodule

// File: tb/dstb_strobe_gen_tb.sv
module dstb_strobe_gen_tb;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int NP = 7;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic in_ready;
    logic [DW-1:0] in_word = 0;
    logic [2:0] in_flags = 0;
    logic [TW-1:0] cfg_len, cfg_cap, cfg_cs_up, cfg_cs_dn;
    logic [NP*TW-1:0] pin_up, pin_dn;
    logic [2*NP-1:0] pin_role;
    logic [NP-1:0] pin_idle;
    logic [1:0] cs_early, cs_late;
    logic [NP-1:0] pin_early, pin_late;
    logic [DW-1:0] bus_o, bus_i = 0, rd_data;
    logic bus_oe, rd_valid;

    always #5 clk = ~clk;

    dstb_strobe_gen #(.DW(DW), .TW(TW), .NPIN(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_word_i(in_word), .in_flags_i(in_flags), .cfg_len_i(cfg_len),
        .cfg_cap_i(cfg_cap), .cfg_cs_up_i(cfg_cs_up), .cfg_cs_dn_i(cfg_cs_dn),
        .pin_up_i(pin_up), .pin_dn_i(pin_dn), .pin_role_i(pin_role),
        .pin_idle_i(pin_idle), .cs_early_o(cs_early), .cs_late_o(cs_late),
        .pin_early_o(pin_early), .pin_late_o(pin_late), .bus_o(bus_o),
        .bus_oe_o(bus_oe), .bus_i(bus_i), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
    );

    typedef struct packed {
        logic          busy;
        logic [NP-1:0] pe, pl;
        logic [1:0]    ce, cl;
        logic          rdy, oe, chk_bus;
        logic [DW-1:0] bus;
        logic          rdv;
        logic [DW-1:0] rdd;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;
    int up[NP], dn[NP], role[NP], idl[NP];
    int len, cap, csu, csd;

    task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_cfg();
        cfg_len = TW'(len); cfg_cap = TW'(cap); cfg_cs_up = TW'(csu); cfg_cs_dn = TW'(csd);
        for (int p = 0; p < NP; p++) begin
            pin_up[p*TW +: TW] = TW'(up[p]);
            pin_dn[p*TW +: TW] = TW'(dn[p]);
            pin_role[2*p +: 2] = 2'(role[p]);
            pin_idle[p] = idl[p][0];
        end
    endtask

    function automatic logic pin_exp(int p, int h, logic rd, logic rs);
        logic act;
        if (role[p] == 2) return rs;                       // R5
        act = (role[p] == 3) || (role[p] == 0 && !rd) || (role[p] == 1 && rd); // R4
        return idl[p][0] ^ (act && h >= up[p] && h < dn[p]);
    endfunction

    function automatic exp_t idle_rec();
        exp_t e = '0;
        e.pe = pin_idle; e.pl = pin_idle; e.ce = 2'b11; e.cl = 2'b11; e.rdy = 1'b1;
        return e;
    endfunction

    // driver: offers one word and queues every expected cycle of its transfer
    task automatic send(input logic [DW-1:0] w, input logic sel, input logic rd,
                        input logic rs, input logic [DW-1:0] va, input logic [DW-1:0] vb);
        exp_t recs[$];
        int ncyc, kc;
        #1;
        in_word = w; in_flags = {rs, rd, sel}; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        ncyc = (len + 1) / 2;
        if (ncyc < 1) ncyc = 1;
        for (int k = 0; k < ncyc; k++) begin
            exp_t e = '0;
            e.busy = 1'b1;
            for (int p = 0; p < NP; p++) begin
                e.pe[p] = pin_exp(p, 2*k, rd, rs);
                e.pl[p] = pin_exp(p, 2*k+1, rd, rs);
            end
            for (int d = 0; d < 2; d++) begin
                e.ce[d] = !((sel == d[0]) && (2*k   >= csu) && (2*k   < csd));
                e.cl[d] = !((sel == d[0]) && (2*k+1 >= csu) && (2*k+1 < csd));
            end
            e.oe = !rd; e.chk_bus = !rd; e.bus = w;
            recs.push_back(e);
        end
        recs.push_back(idle_rec());
        if (rd) begin
            kc = cap / 2;
            recs[kc+1].rdv = 1'b1;
            recs[kc+1].rdd = cap[0] ? vb : va;
            fork
                begin
                    repeat (kc) @(posedge clk);
                    #1 bus_i = va;
                    @(negedge clk);
                    #1 bus_i = vb;
                end
            join_none
        end
        foreach (recs[i]) q.push_back(recs[i]);
    endtask

    task automatic stop_offer();
        #1 in_valid = 1'b0;
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
    endtask

    // monitor: compares one queued cycle per clock
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(in_ready == e.rdy, "R1 ready", DW'(in_ready), DW'(e.rdy));
                chk(pin_early == e.pe, e.busy ? "R3 pin early" : "R7 pin early", DW'(pin_early), DW'(e.pe));
                chk(pin_late == e.pl, e.busy ? "R3 pin late" : "R7 pin late", DW'(pin_late), DW'(e.pl));
                chk(cs_early == e.ce && cs_late == e.cl, "R6 chip select",
                    DW'({cs_early, cs_late}), DW'({e.ce, e.cl}));
                chk(bus_oe == e.oe, "R8 oe", DW'(bus_oe), DW'(e.oe));
                if (e.chk_bus) chk(bus_o == e.bus, "R8 bus", bus_o, e.bus);
                chk(rd_valid == e.rdv, "R9 rd_valid", DW'(rd_valid), DW'(e.rdv));
                if (e.rdv) chk(rd_data == e.rdd, "R9 rd_data", rd_data, e.rdd);
            end
        end
    end

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R4 roles: 0 wr, 1 rd, 2 rs, 3 every transfer
        len = 8; cap = 5; csu = 0; csd = 8;
        up  = '{1, 2, 0, 3, 0, 5, 6};
        dn  = '{5, 6, 0, 4, 3, 7, 9};
        role = '{0, 1, 2, 3, 0, 1, 3};
        idl = '{1, 1, 0, 0, 0, 1, 0};
        apply_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R7)
        chk(in_ready == 1'b1, "R1 reset ready", DW'(in_ready), 1);
        chk(pin_early == pin_idle && pin_late == pin_idle, "R7 reset pins", DW'(pin_early), DW'(pin_idle));
        chk(cs_early == 2'b11 && cs_late == 2'b11, "R6 reset cs", DW'(cs_early), 3);
        chk(!bus_oe && !rd_valid, "R8 reset oe", DW'({bus_oe, rd_valid}), 0);

        // R2 start point, R10: second word offered while the first still runs
        send(16'hA5A5, 1'b0, 1'b0, 1'b0, 0, 0);
        send(16'h3C3C, 1'b1, 1'b0, 1'b1, 0, 0);
        send(16'h0000, 1'b0, 1'b1, 1'b1, 16'h1111, 16'h2222);   // odd capture
        stop_offer();

        // shorter odd length, shifted chip select, even capture
        len = 5; cap = 4; csu = 1; csd = 4;
        apply_cfg();
        send(16'h0000, 1'b1, 1'b1, 1'b0, 16'h4444, 16'h8888);
        send(16'h7E81, 1'b1, 1'b0, 1'b0, 0, 0);
        stop_offer();

        // minimum length: one cycle per word, capture at half-step 1
        len = 2; cap = 1; csu = 0; csd = 2;
        apply_cfg();
        send(16'h0000, 1'b0, 1'b1, 1'b0, 16'h0F0F, 16'hF0F0);
        send(16'hBEEF, 1'b0, 1'b0, 1'b1, 0, 0);
        stop_offer();
        chk(in_ready && pin_early == pin_idle, "R7 final idle", DW'(pin_early), DW'(pin_idle));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule